// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides whether a received CAN frame should be kept. It gets the frame header fields (identifier, extended-format flag, remote flag, data length code and the first two data bytes) in parallel, together with a valid strobe. It compares them against four code bytes and four mask bytes, which come from a register unit outside the block. The decision and a decision strobe appear on registered outputs one clock after the frame.

Two filter layouts are available. In single mode the eight bytes form one long filter. It covers the whole identifier and the remote bit. For standard frames it also covers the first two data bytes. In dual mode the bytes form two shorter filters, and a frame is accepted when either filter matches. For extended frames only the sixteen most significant identifier bits are compared. For standard frames the first filter also checks data byte 0, using an expected value built from two separate nibbles. A mask bit of 1 marks its position as don't care. When the extended controller mode is off, every frame is accepted.

Top module: `can_accept_filter`

## Requirements
- R1: While reset is asserted and after it is released, `dec_valid` and `dec_accept` are 0 until a frame is presented.
- R2: `dec_valid` is 1 exactly in the clock cycle after a cycle with `frm_valid` = 1, and 0 otherwise. `dec_accept` is 0 whenever `dec_valid` is 0. Back-to-back frames each get their own decision.
- R3: With `ext_mode_en` = 0 every frame is accepted, whatever the code, mask and frame contents.
- R4: Single mode (`single_sel` = 1), extended frame: the 29-bit expected identifier is {code byte0, code byte1, code byte2, code byte3[7:3]} and the mask uses the same layout. The expected remote bit is code byte3[2], with mask byte3[2] as its don't-care. Code byte k is `code_bytes[8k+7:8k]`, and mask byte k (0..3) is `mask_bytes[8k+7:8k]`.
- R5: Single mode, standard frame: the 11-bit identifier is compared against {byte0, byte1[7:5]}. The expected remote bit is byte1[4], with its don't-care at mask byte1[4].
- R6: Single mode, standard frame that passes R5: it is accepted at once if it is a remote frame or has a DLC of 0.
- R7: Single mode, standard data frame with DLC ≥ 1: data byte 0 must match code byte2 under mask byte2. If DLC ≥ 2, data byte 1 must also match code byte3 under mask byte3. With DLC = 1, data byte 1 is ignored.
- R8: Dual mode (`single_sel` = 0), extended frame: filter 1 compares identifier bits 28..13 with {code0, code1} under {mask0, mask1}, and filter 2 does the same with bytes 2 and 3. Identifier bits 12..0 and the remote flag are ignored.
- R9: Dual mode, standard frame, filter 1: the identifier and remote bit are checked as in R5 using bytes 0 and 1. Data byte 0 must also match {code1[3:0], code3[3:0]} under {mask1[3:0], mask3[3:0]}, whatever the DLC.
- R10: Dual mode, standard frame, filter 2: the identifier and remote bit are checked as in R5 using bytes 2 and 3, with no data check. The frame is accepted if filter 1 or filter 2 matches.
- R11: A mask bit of 1 makes the matching code bit don't care, and a mask bit of 0 requires equality.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_valid | input | 1 | Frame fields valid this cycle |
| frm_ext | input | 1 | 1 = extended (29-bit) identifier |
| frm_rtr | input | 1 | 1 = remote frame |
| frm_id | input | 29 | Identifier; a standard id sits in bits 10..0 |
| frm_dlc | input | 4 | Data length code |
| frm_d0 | input | 8 | Data byte 0 |
| frm_d1 | input | 8 | Data byte 1 |
| ext_mode_en | input | 1 | Extended controller mode; 0 accepts everything |
| single_sel | input | 1 | 1 = single filter, 0 = dual filter |
| code_bytes | input | 32 | Code bytes 0..3, byte k at bits 8k+7..8k |
| mask_bytes | input | 32 | Mask bytes 0..3, 1 = don't care |
| dec_valid | output | 1 | Decision strobe, one cycle after frm_valid |
| dec_accept | output | 1 | 1 = frame accepted |

## Verification
Two events can land in the same cycle. One is the output of the decision for frame N. The other is the arrival of frame N+1, which may come with a different mode, code or mask. The bench drives frames on consecutive cycles with all settings changing between them. It checks that each registered decision matches the model's verdict for the inputs of the cycle before, and not for the current ones. In dual mode both filters can also hit on the same frame. Directed and random cases make filter 1 and filter 2 match alone and together, and the bench checks that the result is their logical OR.

// File: rtl/caf_pkg.sv
package caf_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_CODE   = 4;
  localparam int CM_W       = BYTE_W * NUM_CODE;
  localparam int EXT_ID_W   = 29;
  localparam int STD_ID_W   = 11;
  localparam int DUAL_EXT_W = 2 * BYTE_W;
  localparam int DLC_W      = 4;
  localparam int NUM_DUAL   = 2;
  localparam int NIB_W      = BYTE_W / 2;

  typedef logic [BYTE_W-1:0]   byte_t;
  typedef logic [EXT_ID_W-1:0] idw_t;

  function automatic byte_t pick(input logic [CM_W-1:0] v, input int k);
    return v[k*BYTE_W +: BYTE_W];
  endfunction

  // equality on every bit whose don't-care flag is 0
  function automatic logic masked_eq(input idw_t got, input idw_t exp, input idw_t dc);
    return ((got ^ exp) & ~dc) == '0;
  endfunction

  function automatic logic byte_eq(input byte_t got, input byte_t exp, input byte_t dc);
    return ((got ^ exp) & ~dc) == '0;
  endfunction

  // 11-bit identifier field from a high byte and the top three bits of a low byte
  function automatic idw_t std_field(input byte_t hi, input byte_t lo);
    return EXT_ID_W'({hi, lo[BYTE_W-1 -: STD_ID_W-BYTE_W]});
  endfunction

  // 29-bit identifier field over four bytes
  function automatic idw_t ext_field(input byte_t b0, input byte_t b1,
                                     input byte_t b2, input byte_t b3);
    return {b0, b1, b2, b3[BYTE_W-1 -: EXT_ID_W-3*BYTE_W]};
  endfunction

  function automatic logic bit_ok(input logic got, input logic exp, input logic dc);
    return dc | (got == exp);
  endfunction
endpackage

// File: rtl/caf_single_match.sv
module caf_single_match
  import caf_pkg::*;
(
  input  logic                 frm_ext,
  input  logic                 frm_rtr,
  input  logic [EXT_ID_W-1:0]  frm_id,
  input  logic [DLC_W-1:0]     frm_dlc,
  input  logic [BYTE_W-1:0]    frm_d0,
  input  logic [BYTE_W-1:0]    frm_d1,
  input  logic [CM_W-1:0]      code_bytes,
  input  logic [CM_W-1:0]      mask_bytes,
  output logic                 id_hit,
  output logic                 accept
);
  localparam int EXT_RTR_BIT = 2;
  localparam int STD_RTR_BIT = 4;

  byte_t c0, c1, c2, c3, m0, m1, m2, m3;
  logic  ext_ok, std_ok, d0_ok, d1_ok, data_ok;

  always_comb begin
    c0 = pick(code_bytes, 0); c1 = pick(code_bytes, 1);
    c2 = pick(code_bytes, 2); c3 = pick(code_bytes, 3);
    m0 = pick(mask_bytes, 0); m1 = pick(mask_bytes, 1);
    m2 = pick(mask_bytes, 2); m3 = pick(mask_bytes, 3);

    ext_ok = masked_eq(frm_id, ext_field(c0, c1, c2, c3), ext_field(m0, m1, m2, m3))
           & bit_ok(frm_rtr, c3[EXT_RTR_BIT], m3[EXT_RTR_BIT]);
    std_ok = masked_eq(EXT_ID_W'(frm_id[STD_ID_W-1:0]), std_field(c0, c1), std_field(m0, m1))
           & bit_ok(frm_rtr, c1[STD_RTR_BIT], m1[STD_RTR_BIT]);

    d0_ok   = byte_eq(frm_d0, c2, m2);
    d1_ok   = byte_eq(frm_d1, c3, m3);
    data_ok = frm_rtr | (frm_dlc == '0) | (d0_ok & ((frm_dlc < DLC_W'(2)) | d1_ok));

    id_hit = frm_ext ? ext_ok : std_ok;
    accept = id_hit & (frm_ext | data_ok);
  end
endmodule

// File: rtl/caf_dual_match.sv
module caf_dual_match
  import caf_pkg::*;
(
  input  logic                 frm_ext,
  input  logic                 frm_rtr,
  input  logic [EXT_ID_W-1:0]  frm_id,
  input  logic [BYTE_W-1:0]    frm_d0,
  input  logic [CM_W-1:0]      code_bytes,
  input  logic [CM_W-1:0]      mask_bytes,
  output logic [NUM_DUAL-1:0]  hit
);
  localparam int STD_RTR_BIT = 4;

  for (genvar k = 0; k < NUM_DUAL; k++) begin : g_filt
    byte_t ch, cl, mh, ml;
    logic  ext_ok, std_ok, data_ok;

    always_comb begin
      ch = pick(code_bytes, 2*k);
      cl = pick(code_bytes, 2*k+1);
      mh = pick(mask_bytes, 2*k);
      ml = pick(mask_bytes, 2*k+1);
      ext_ok = masked_eq(EXT_ID_W'(frm_id[EXT_ID_W-1 -: DUAL_EXT_W]),
                         EXT_ID_W'({ch, cl}), EXT_ID_W'({mh, ml}));
      std_ok = masked_eq(EXT_ID_W'(frm_id[STD_ID_W-1:0]), std_field(ch, cl), std_field(mh, ml))
             & bit_ok(frm_rtr, cl[STD_RTR_BIT], ml[STD_RTR_BIT]);
    end

    if (k == 0) begin : g_data
      byte_t exp_d, dc_d;
      always_comb begin
        exp_d   = {cl[NIB_W-1:0], code_bytes[3*BYTE_W +: NIB_W]};
        dc_d    = {ml[NIB_W-1:0], mask_bytes[3*BYTE_W +: NIB_W]};
        data_ok = byte_eq(frm_d0, exp_d, dc_d);
      end
    end else begin : g_nodata
      assign data_ok = 1'b1;
    end

    assign hit[k] = frm_ext ? ext_ok : (std_ok & data_ok);
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import caf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frm_valid,
  input  logic                 frm_ext,
  input  logic                 frm_rtr,
  input  logic [EXT_ID_W-1:0]  frm_id,
  input  logic [DLC_W-1:0]     frm_dlc,
  input  logic [BYTE_W-1:0]    frm_d0,
  input  logic [BYTE_W-1:0]    frm_d1,
  input  logic                 ext_mode_en,
  input  logic                 single_sel,
  input  logic [CM_W-1:0]      code_bytes,
  input  logic [CM_W-1:0]      mask_bytes,
  output logic                 dec_valid,
  output logic                 dec_accept
);
  // named internal events for the assertions
  logic                single_id_hit;
  logic                single_acc;
  logic [NUM_DUAL-1:0] dual_hits;
  logic                verdict;

  caf_single_match u_single (
    .frm_ext    (frm_ext),
    .frm_rtr    (frm_rtr),
    .frm_id     (frm_id),
    .frm_dlc    (frm_dlc),
    .frm_d0     (frm_d0),
    .frm_d1     (frm_d1),
    .code_bytes (code_bytes),
    .mask_bytes (mask_bytes),
    .id_hit     (single_id_hit),
    .accept     (single_acc)
  );

  caf_dual_match u_dual (
    .frm_ext    (frm_ext),
    .frm_rtr    (frm_rtr),
    .frm_id     (frm_id),
    .frm_d0     (frm_d0),
    .code_bytes (code_bytes),
    .mask_bytes (mask_bytes),
    .hit        (dual_hits)
  );

  always_comb begin
    if (!ext_mode_en)    verdict = 1'b1;
    else if (single_sel) verdict = single_acc;
    else                 verdict = |dual_hits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= frm_valid;
      dec_accept <= frm_valid & verdict;
    end
  end

  assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> dec_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !dec_valid);
  assert_accept_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_valid);
  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !ext_mode_en) |=> dec_accept);
  assert_remote_shortcut_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && ext_mode_en && single_sel && !frm_ext && frm_rtr && single_id_hit) |=> dec_accept);
  assert_dual_or_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && ext_mode_en && !single_sel && (dual_hits != '0)) |=> dec_accept);
  assert_dual_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && ext_mode_en && !single_sel && (dual_hits == '0)) |=> !dec_accept);
endmodule

// File: tb/tb_can_accept_filter.sv
module tb_can_accept_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0, frm_ext = 1'b0, frm_rtr = 1'b0;
  logic [28:0] frm_id = '0;
  logic [3:0]  frm_dlc = '0;
  logic [7:0]  frm_d0 = '0, frm_d1 = '0;
  logic        ext_mode_en = 1'b0, single_sel = 1'b0;
  logic [31:0] code_bytes = '0, mask_bytes = '0;
  logic        dec_valid, dec_accept;

  int checks = 0;
  int fails  = 0;
  bit    pend_v = 1'b0;
  bit    pend_exp = 1'b0;
  string pend_req = "R2";

  always #5 clk = ~clk;

  can_accept_filter dut (.*);

  // independent model: bit-by-bit field comparison
  function automatic bit fld_ok(int w, logic [31:0] got, logic [31:0] exp, logic [31:0] dc);
    for (int i = 0; i < w; i++)
      if (!dc[i] && (got[i] !== exp[i])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit model(bit en, bit sgl, bit ext, bit rtr, logic [28:0] id,
                               logic [3:0] dlc, logic [7:0] d0, logic [7:0] d1,
                               logic [31:0] cd, logic [31:0] mk);
    logic [7:0] c [4];
    logic [7:0] m [4];
    bit f1, f2;
    for (int k = 0; k < 4; k++) begin
      c[k] = cd[8*k +: 8];
      m[k] = mk[8*k +: 8];
    end
    if (!en) return 1'b1;                                   // R3
    if (sgl) begin
      if (ext)                                              // R4
        return fld_ok(29, {3'b0, id}, {3'b0, c[0], c[1], c[2], c[3][7:3]},
                      {3'b0, m[0], m[1], m[2], m[3][7:3]})
               && (m[3][2] || rtr == c[3][2]);
      if (!(fld_ok(11, {21'b0, id[10:0]}, {21'b0, c[0], c[1][7:5]}, {21'b0, m[0], m[1][7:5]})
            && (m[1][4] || rtr == c[1][4]))) return 1'b0;   // R5
      if (rtr || dlc == 0) return 1'b1;                     // R6
      if (!fld_ok(8, {24'b0, d0}, {24'b0, c[2]}, {24'b0, m[2]})) return 1'b0;  // R7
      if (dlc < 2) return 1'b1;
      return fld_ok(8, {24'b0, d1}, {24'b0, c[3]}, {24'b0, m[3]});
    end
    if (ext) begin                                          // R8
      f1 = fld_ok(16, {16'b0, id[28:13]}, {16'b0, c[0], c[1]}, {16'b0, m[0], m[1]});
      f2 = fld_ok(16, {16'b0, id[28:13]}, {16'b0, c[2], c[3]}, {16'b0, m[2], m[3]});
      return f1 || f2;
    end
    f1 = fld_ok(11, {21'b0, id[10:0]}, {21'b0, c[0], c[1][7:5]}, {21'b0, m[0], m[1][7:5]})
         && (m[1][4] || rtr == c[1][4])
         && fld_ok(8, {24'b0, d0}, {24'b0, c[1][3:0], c[3][3:0]},
                   {24'b0, m[1][3:0], m[3][3:0]});          // R9
    f2 = fld_ok(11, {21'b0, id[10:0]}, {21'b0, c[2], c[3][7:5]}, {21'b0, m[2], m[3][7:5]})
         && (m[3][4] || rtr == c[3][4]);                    // R10
    return f1 || f2;
  endfunction

  function automatic logic [31:0] ext_pack(logic [28:0] id, bit rtr);
    return {id[4:0], rtr, 2'b00, id[12:5], id[20:13], id[28:21]};
  endfunction

  function automatic logic [31:0] std_pack(logic [10:0] id, bit rtr, logic [7:0] b2, logic [7:0] b3);
    return {b3, b2, id[2:0], rtr, 4'h0, id[10:3]};
  endfunction

  task automatic chk(bit ok, string req, bit gv, bit ga, bit ev, bit ea);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got valid=%0b accept=%0b, expected valid=%0b accept=%0b",
               req, gv, ga, ev, ea);
    end
  endtask

  // at each falling edge: judge the previous cycle's frame, then drive the next
  task automatic step(bit v, bit en, bit sgl, bit ext, bit rtr, logic [28:0] id,
                      logic [3:0] dlc, logic [7:0] d0, logic [7:0] d1,
                      logic [31:0] cd, logic [31:0] mk, string req);
    @(negedge clk);
    if (pend_v)
      chk(dec_valid === 1'b1 && dec_accept === pend_exp, pend_req,
          dec_valid, dec_accept, 1'b1, pend_exp);
    else
      chk(dec_valid === 1'b0 && dec_accept === 1'b0, "R2",
          dec_valid, dec_accept, 1'b0, 1'b0);
    frm_valid = v; ext_mode_en = en; single_sel = sgl; frm_ext = ext; frm_rtr = rtr;
    frm_id = id; frm_dlc = dlc; frm_d0 = d0; frm_d1 = d1;
    code_bytes = cd; mask_bytes = mk;
    pend_v   = v;
    pend_exp = v && model(en, sgl, ext, rtr, id, dlc, d0, d1, cd, mk);
    pend_req = req;
  endtask

  task automatic idle();
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0, '0, '0, '1, '0, "R2");
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [28:0] a_id;
    logic [10:0] s_id;
    logic [31:0] cd;
    void'($urandom(32'd1357));
    a_id = 29'h0ABCDE1;
    s_id = 11'h5A3;

    repeat (3) @(negedge clk);
    chk(dec_valid === 1'b0 && dec_accept === 1'b0, "R1", dec_valid, dec_accept, 1'b0, 1'b0);
    rst_n = 1'b1;
    idle();

    // R3: extended mode off accepts a mismatching frame
    step(1, 0, 1, 1, 0, ~a_id, 4'd8, 8'h11, 8'h22, ext_pack(a_id, 0), '0, "R3");
    // R4 / R11 single extended
    step(1, 1, 1, 1, 0, a_id,       4'd2, 8'h00, 8'h00, ext_pack(a_id, 0), '0, "R4");
    step(1, 1, 1, 1, 0, a_id ^ 29'h1, 4'd2, 8'h00, 8'h00, ext_pack(a_id, 0), '0, "R4");
    step(1, 1, 1, 1, 0, a_id ^ 29'h1, 4'd2, 8'h00, 8'h00, ext_pack(a_id, 0), 32'h0800_0000, "R11");
    step(1, 1, 1, 1, 1, a_id,       4'd0, 8'h00, 8'h00, ext_pack(a_id, 0), '0, "R4");
    step(1, 1, 1, 1, 1, a_id,       4'd0, 8'h00, 8'h00, ext_pack(a_id, 0), 32'h0400_0000, "R4");
    // R5 / R6 / R7 single standard
    step(1, 1, 1, 0, 1, {18'b0, s_id}, 4'd5, 8'h00, 8'h00, std_pack(s_id, 1, 8'h3C, 8'hC3), '0, "R6");
    step(1, 1, 1, 0, 0, {18'b0, s_id}, 4'd0, 8'h99, 8'h99, std_pack(s_id, 0, 8'h3C, 8'hC3), '0, "R6");
    step(1, 1, 1, 0, 0, {18'b0, s_id}, 4'd1, 8'h3C, 8'h00, std_pack(s_id, 0, 8'h3C, 8'hC3), '0, "R7");
    step(1, 1, 1, 0, 0, {18'b0, s_id}, 4'd2, 8'h3C, 8'h00, std_pack(s_id, 0, 8'h3C, 8'hC3), '0, "R7");
    step(1, 1, 1, 0, 0, {18'b0, s_id}, 4'd2, 8'h3C, 8'hC3, std_pack(s_id, 0, 8'h3C, 8'hC3), '0, "R7");
    step(1, 1, 1, 0, 0, {18'b0, s_id}, 4'd1, 8'h3D, 8'hC3, std_pack(s_id, 0, 8'h3C, 8'hC3), '0, "R7");
    step(1, 1, 1, 0, 0, {18'b0, s_id}, 4'd1, 8'h3D, 8'hC3, std_pack(s_id, 0, 8'h3C, 8'hC3), 32'h0001_0000, "R11");
    step(1, 1, 1, 0, 0, {18'b0, s_id ^ 11'h1}, 4'd0, 8'h00, 8'h00, std_pack(s_id, 0, 8'h3C, 8'hC3), '0, "R5");
    step(1, 1, 1, 0, 1, {18'b0, s_id}, 4'd0, 8'h00, 8'h00, std_pack(s_id, 0, 8'h3C, 8'hC3), '0, "R5");
    // R8 / R10 dual extended
    cd = {8'hFF, 8'hFF, a_id[20:13], a_id[28:21]};
    step(1, 1, 0, 1, 1, a_id ^ 29'h1FFF, 4'd3, 8'h00, 8'h00, cd, '0, "R8");
    step(1, 1, 0, 1, 0, a_id ^ 29'h2000, 4'd3, 8'h00, 8'h00, cd, '0, "R8");
    cd = {(a_id ^ 29'h2000) >> 13, a_id[20:13], a_id[28:21]};
    step(1, 1, 0, 1, 0, a_id ^ 29'h2000, 4'd3, 8'h00, 8'h00, cd, '0, "R10");
    // R9 / R10 dual standard
    cd = {8'hE5, 8'hFF, s_id[2:0], 1'b0, 4'hA, s_id[10:3]};
    step(1, 1, 0, 0, 0, {18'b0, s_id}, 4'd1, 8'hA5, 8'h00, cd, '0, "R9");
    step(1, 1, 0, 0, 0, {18'b0, s_id}, 4'd1, 8'hA4, 8'h00, cd, '0, "R9");
    step(1, 1, 0, 0, 0, {18'b0, s_id}, 4'd0, 8'hA4, 8'h00, cd, '0, "R9");
    step(1, 1, 0, 0, 0, {18'b0, s_id}, 4'd0, 8'hA4, 8'h00, cd, 32'h0100_0000, "R11");
    step(1, 1, 0, 0, 0, 29'h7FF, 4'd4, 8'h00, 8'h00, cd, '0, "R10");
    step(1, 1, 0, 0, 1, 29'h7FF, 4'd4, 8'h00, 8'h00, cd, '0, "R10");
    idle();

    // random back-to-back frames with changing settings
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] rc, rm;
      logic [28:0] rid;
      bit en, sgl, ext, rtr, vv;
      int sel;
      rc  = $urandom;
      rm  = $urandom & $urandom;
      en  = ($urandom % 8) != 0;
      sgl = $urandom % 2;
      ext = $urandom % 2;
      rtr = ($urandom % 4) == 0;
      vv  = ($urandom % 6) != 0;
      rid = 29'($urandom);
      sel = $urandom % 4;
      if (sel == 0 && ext)  rid = {rc[7:0], rc[15:8], rc[23:16], rc[31:27]};
      if (sel == 0 && !ext) rid = {18'b0, rc[7:0], rc[15:13]};
      if (sel == 1 && !ext) rid = {18'b0, rc[23:16], rc[31:29]};
      if (sel == 1 && ext)  rid[28:13] = {rc[23:16], rc[31:24]};
      if (!ext) rid[28:11] = '0;
      if (($urandom % 4) == 0) rid[$urandom % 11] ^= 1'b1;
      step(vv, en, sgl, ext, rtr, rid, 4'($urandom % 9), 8'($urandom), 8'($urandom),
           rc, rm, sgl ? (ext ? "R4" : "R7") : (ext ? "R8" : "R10"));
    end
    idle();
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule